// File: doc/BRIEF.md
# USB Interrupt Status with Bus-Idle Suspend Detection

This block forms the 8-bit interrupt status word of a USB device controller that also contains a hub. Its lower six bits summarise six per-endpoint source vectors: four function endpoints and two hub endpoints. Each summary bit is a live OR of its own vector. Software cannot write these bits. They clear only when the endpoint logic clears its own source vector.

The upper two bits report bus events, and the two have different clear rules. The suspend flag rises after the bus has sat in idle (J) for an unbroken stretch of USB clock cycles. Software clears it by writing zero. The resume flag rises when the bus leaves J while resume detection is enabled. It clears only when that enable is removed. Detection runs entirely on the USB clock, so it works while the CPU clock is stopped. An interrupt request output is high whenever any status bit is set.

Line state arrives already synchronised to the USB clock, as a 2-bit code: 00 = SE0, 01 = J, 10 = K, 11 = SE1.

Top module: `usb_irq_status`

## Requirements
- R1: After reset every bit of `status` is 0. Bit layout: bits 0–3 are function endpoints 0–3, bit 4 is hub endpoint 0, bit 5 is hub endpoint 1, bit 6 is suspend and bit 7 is resume.
- R2: Endpoint summary bit i is 1 exactly while slice `ep_src[8*i+7:8*i]` has at least one bit set, in the same cycle.
- R3: Register writes never change the endpoint summary bits or the resume bit.
- R4: The suspend bit becomes 1 on the clock edge that samples the IDLE_CYCLES-th consecutive J code (default 144000, which is 3 ms at 48 MHz). It is not yet 1 one edge earlier.
- R5: Any sampled non-J code restarts the idle count from zero.
- R6: A write with `wr_data[6]` = 0 clears the suspend bit on the next edge. A write with `wr_data[6]` = 1 leaves it unchanged.
- R7: Suspend sets at most once per idle period. Once cleared during continued J, it stays 0 until the bus leaves J and then idles for a full period again.
- R8: With `resume_en` = 1, a sampled change from J to K or from J to SE0 sets the resume bit on that edge. A change from J to SE1 does not set it.
- R9: With `resume_en` = 0, the resume bit is 0 on the next edge and bus activity does not set it.
- R10: `irq` is 1 exactly when some bit of `status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_usb | input | 1 | 48 MHz USB clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Synchronised bus code (00 SE0, 01 J, 10 K, 11 SE1) |
| ep_src | input | 48 | Six 8-bit per-endpoint source vectors, endpoint i in bits 8i+7:8i |
| resume_en | input | 1 | Resume detection enable; low clears the resume bit |
| wr_en | input | 1 | CPU write strobe to the status register |
| wr_data | input | 8 | CPU write data; only bit 6 has an effect |
| status | output | 8 | Status register value |
| irq | output | 1 | Interrupt request, OR of all status bits |

## Verification
The hardest situation to reach is the once-per-idle rule. A cleared suspend flag must stay low through a long run of J, then rise again only after a single non-J cycle and another full idle period. The bench shrinks IDLE_CYCLES so it can hold J for many multiples of the period after a clear. It then inserts one K cycle between two idle runs that each stop one cycle short of the count. The resume clear rule is driven by writing zeros while the resume bit is set, and only afterwards dropping the enable.

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int NUM_EP      = 6,
  parameter int SRC_W       = 8,
  parameter int IDLE_CYCLES = 144000
) (
  input  logic                    clk_usb,
  input  logic                    rst_n,
  input  logic [1:0]              line_state,
  input  logic [NUM_EP*SRC_W-1:0] ep_src,
  input  logic                    resume_en,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  output logic [7:0]              status,
  output logic                    irq
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [1:0] LS_J = 2'b01;
  localparam logic [1:0] LS_K = 2'b10;
  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam int SUSP_BIT = 6;

  logic [NUM_EP-1:0] ep_any;
  logic [CNT_W-1:0]  idle_cnt;
  logic              idle_done;
  logic              susp_q, rsm_q;
  logic [1:0]        prev_ls;
  logic              is_j, left_j, idle_hit, susp_clr;
  logic              unused_wr;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign ep_any[i] = |ep_src[i*SRC_W +: SRC_W];
  end

  assign is_j      = (line_state == LS_J);
  assign left_j    = (prev_ls == LS_J) && (line_state == LS_K || line_state == LS_SE0);
  assign idle_hit  = is_j && !idle_done && (idle_cnt == CNT_W'(IDLE_CYCLES - 1));
  assign susp_clr  = wr_en && !wr_data[SUSP_BIT];
  assign unused_wr = ^{wr_data[7], wr_data[5:0]};

  always_ff @(posedge clk_usb) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      idle_done <= 1'b0;
    end else if (!is_j) begin
      idle_cnt  <= '0;
      idle_done <= 1'b0;
    end else if (idle_hit) begin
      idle_done <= 1'b1;
    end else if (!idle_done) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_usb) begin
    if (!rst_n)          susp_q <= 1'b0;
    else if (idle_hit)   susp_q <= 1'b1;
    else if (susp_clr)   susp_q <= 1'b0;
  end

  always_ff @(posedge clk_usb) begin
    if (!rst_n) begin
      prev_ls <= LS_SE0;
      rsm_q   <= 1'b0;
    end else begin
      prev_ls <= line_state;
      if (!resume_en)  rsm_q <= 1'b0;
      else if (left_j) rsm_q <= 1'b1;
    end
  end

  if (NUM_EP < 6) begin : g_pad
    assign status = {rsm_q, susp_q, {(6-NUM_EP){1'b0}}, ep_any};
  end else begin : g_nopad
    assign status = {rsm_q, susp_q, ep_any[5:0]};
  end
  assign irq = |status;

  // R4
  susp_after_idle_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    $rose(susp_q) |-> $past(line_state == LS_J));
  // R6
  susp_clear_by_zero_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    $fell(susp_q) |-> $past(wr_en && !wr_data[SUSP_BIT]));
  // R8
  rsm_needs_enable_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    $rose(rsm_q) |-> $past(resume_en) && $past(prev_ls == LS_J));
  // R9
  rsm_clear_by_enable_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    $fell(rsm_q) |-> $past(!resume_en));
  // R5
  idle_restart_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    !is_j |=> idle_cnt == '0);
  // R3
  ep_write_ignored_chk: assert property (@(posedge clk_usb) disable iff (!rst_n)
    wr_en && $stable(ep_src) |-> $stable(ep_any));
endmodule

// File: tb/usb_irq_status_tb.sv
module usb_irq_status_tb_top;
  localparam int PER = 10;
  localparam int N   = 50;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00, SE1 = 2'b11;

  logic clk = 0, rst_n = 0;
  logic [1:0]  line_state = SE0;
  logic [47:0] ep_src = '0;
  logic resume_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  usb_irq_status #(.IDLE_CYCLES(N)) dut_i (
    .clk_usb(clk), .rst_n(rst_n), .line_state(line_state), .ep_src(ep_src),
    .resume_en(resume_en), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .irq(irq));

  function automatic logic [5:0] exp_ep(logic [47:0] s);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = |s[i*8 +: 8];
    return r;
  endfunction

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(PER/4);
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    cyc(3);
    chk("R1 reset", status, 8'h00);
    chk("R10 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    line_state = K;
    cyc(2);
    // R4: idle count boundary
    line_state = J;
    cyc(N-1);
    chk("R4 before count", {7'd0, status[6]}, 8'h00);
    cyc(1);
    chk("R4 at count", {7'd0, status[6]}, 8'h01);
    chk("R10 irq on suspend", {7'd0, irq}, 8'h01);
    // R6: write 1 ignored, write 0 clears
    wr_en = 1; wr_data = 8'hFF;
    cyc(1);
    chk("R6 write one", {7'd0, status[6]}, 8'h01);
    wr_data = 8'h00;
    cyc(1);
    wr_en = 0;
    chk("R6 write zero", {7'd0, status[6]}, 8'h00);
    // R7: continued J does not re-set
    cyc(3*N);
    chk("R7 no re-set", {7'd0, status[6]}, 8'h00);
    // R5: restart on non-J
    line_state = K; cyc(1);
    line_state = J; cyc(N-1);
    line_state = K; cyc(1);
    line_state = J; cyc(N-1);
    chk("R5 restarted", {7'd0, status[6]}, 8'h00);
    cyc(1);
    chk("R5 full period", {7'd0, status[6]}, 8'h01);
    chk("R9 no resume when disabled", {7'd0, status[7]}, 8'h00);
    line_state = K;
    wr_en = 1; wr_data = 8'h00; cyc(1); wr_en = 0;
    chk("R6 clear again", status, 8'h00);
    // R8: J->K
    resume_en = 1; line_state = J; cyc(2);
    line_state = K; cyc(1);
    chk("R8 J to K", {7'd0, status[7]}, 8'h01);
    line_state = J;
    wr_en = 1; wr_data = 8'h00; cyc(1);
    wr_data = 8'hFF; cyc(1); wr_en = 0;
    chk("R3 resume write", {7'd0, status[7]}, 8'h01);
    resume_en = 0; cyc(1);
    chk("R9 disable clears", {7'd0, status[7]}, 8'h00);
    resume_en = 1; cyc(1);
    line_state = SE0; cyc(1);
    chk("R8 J to SE0", {7'd0, status[7]}, 8'h01);
    resume_en = 0; line_state = J; cyc(1);
    resume_en = 1; cyc(1);
    line_state = SE1; cyc(1);
    chk("R8 J to SE1 ignored", {7'd0, status[7]}, 8'h00);
    resume_en = 0; line_state = K; cyc(1);
    // R2/R3/R10 random
    void'($urandom(32'd1234));
    for (int t = 0; t < 300; t++) begin
      logic [47:0] s;
      for (int e = 0; e < 6; e++) begin
        logic [7:0] v;
        v = 8'($urandom);
        if ($urandom_range(0, 2) != 0) v = 8'h00;
        s[e*8 +: 8] = v;
      end
      if (t == 10) s = '0;
      if (t == 11) s = 48'h8000_0000_0001;
      ep_src = s;
      wr_en = 1'($urandom);
      wr_data = 8'($urandom);
      #1;
      chk("R2 summary", {2'b00, status[5:0]}, {2'b00, exp_ep(s)});
      chk("R10 irq", {7'd0, irq}, {7'd0, |exp_ep(s)});
      cyc(1);
      chk("R3 after write", status, {2'b00, exp_ep(s)});
    end
    wr_en = 0; ep_src = '0; cyc(1);
    chk("R2 all clear", status, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PER*200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule